// File: doc/BRIEF.md
# PPP Transmit Octet Framer

This block turns a byte-wide packet stream into a continuous octet-synchronous HDLC-like line stream. Each packet is enclosed by 0x7E flag octets. A frame check sequence (FCS) is added after the payload. Any payload or FCS octet that equals 0x7E or 0x7D is escaped. The downstream side pulls exactly one octet on every cycle in which it raises `out_en`. When no packet is waiting, the line carries flags. Two frames sent back to back share a single flag, which closes the first frame and opens the second.

Packets arrive with valid, start, end and error markers and a ready handshake. The ready signal drops for one cycle whenever a stuffed octet needs its second line byte. A packet can be cut short in two ways. The first is an error marker given with its last octet. The second is the source going empty in the middle of a packet while the line wants a byte. In both cases the frame is closed with the abort sequence 0x7D 0x7E, and no FCS is sent. An underflowed packet also has its remaining octets discarded up to its end marker. One-cycle event strobes report good frames, error aborts and underflows.

The controller is a seven-state machine, listed here with its transitions:
- IDLE sends flags. It latches the CRC width and moves to DATA when a start-of-packet octet is offered and `out_en` is high.
- DATA sends payload octets. It goes to ESC2 when an octet needs escaping. At the end of the packet it goes to FCS, or to ABT_ESC when the error marker is set. If the input is empty while `out_en` is high, it goes to ABT_FLAG, which is the underflow case.
- ESC2 sends the escaped octet XOR 0x20. It then returns to DATA, FCS, ABT_ESC or IDLE.
- FCS sends the check octets least significant first, passing through ESC2 when an octet needs escaping. After the last check octet it goes to IDLE.
- ABT_ESC sends 0x7D and then moves to ABT_FLAG.
- ABT_FLAG sends 0x7E. It then goes to DROP after an underflow, or to IDLE otherwise.
- DROP sends flags and accepts input octets without sending them until an end marker arrives. It then goes to IDLE.

Top module: `ppp_tx_framer`

## Requirements
- R1: The FCS always follows the payload. With `crc32_sel`=0 it is CRC-16 (x^16+x^12+x^5+1); with `crc32_sel`=1 it is CRC-32. In both cases the CRC is preset to all ones, fed LSB first per octet, and complemented, and the FCS is sent least significant octet first. For ASCII "123456789" the FCS octets are 6E 90 (CRC-16) and 26 39 F4 CB (CRC-32). The width is sampled while idle and held for the whole frame.
- R2: Every payload or FCS octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. All other octet values are sent unchanged.
- R3: While no packet is pending, every octet sent is 0x7E.
- R4: When the next packet is already offered as a frame ends, exactly one 0x7E separates the two frames.
- R5: One octet is sent per cycle with `out_en` high. While `out_en` is low, no octet is accepted outside DROP and the frame content is unchanged.
- R6: `in_ready` is low in the cycle that carries the second byte of an escaped payload octet. A run of escaped octets is therefore accepted at one per two cycles.
- R7: An octet with `in_eop`=1 and `in_err`=1 is still sent. The frame then ends with 0x7D 0x7E and no FCS, and `ev_error` pulses in the cycle after that octet is accepted.
- R8: If `in_valid` is low in DATA while `out_en` is high, the framer sends 0x7D 0x7E and `ev_underflow` pulses in the next cycle. The rest of that packet, up to its end marker, is discarded. The following packet is framed normally.
- R9: `in_valid` low between packets only adds flags and never raises `ev_underflow`.
- R10: `ev_good` pulses in the cycle after an end octet with `in_err`=0 is accepted. At most one event strobe is high in any cycle.
- R11: During reset and right after it, `out_data` is 0x7E, `in_ready` is low and all event strobes are low.
- R12: A packet of a single octet (start and end markers set together) is framed with its FCS like any other packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crc32_sel | input | 1 | 0: CRC-16 FCS, 1: CRC-32 FCS |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input octet |
| in_sop | input | 1 | First octet of a packet |
| in_eop | input | 1 | Last octet of a packet |
| in_err | input | 1 | With in_eop: abort this packet |
| in_ready | output | 1 | Octet accepted this cycle when in_valid is also high |
| out_en | input | 1 | Downstream takes an octet this cycle |
| out_data | output | 8 | Line octet |
| ev_good | output | 1 | Pulse: packet closed with FCS |
| ev_error | output | 1 | Pulse: packet aborted by error marker |
| ev_underflow | output | 1 | Pulse: packet aborted by input running dry |

## Verification
Two pairs of functions can coincide in a single cycle.

The first pair is escape expansion and end of packet. A stuffed octet that carries the end marker must finish its two-byte escape before the FCS starts, or before the abort sequence when the error marker is also set. The bench provokes this with a packet that ends in 0x7E and an error packet that ends in 0x7D.

The second pair is FCS stuffing and flag sharing. A stuffed FCS octet is followed directly by the one flag shared with the next frame. The bench searches for a payload whose FCS contains 0x7E or 0x7D and sends frames back to back.

A scoreboard cuts the line stream at flags and compares every frame octet by octet with a model built from the requirements. It also checks the number of flags before frames that were meant to share a flag.

// File: rtl/ppp_tx_pkg.sv
package ppp_tx_pkg;
    localparam int OCTET_W   = 8;
    localparam int FCS_MAX_W = 32;
    localparam int FCS_LO_W  = 16;

    localparam logic [OCTET_W-1:0] FLAG_OCT = 8'h7E;
    localparam logic [OCTET_W-1:0] ESC_OCT  = 8'h7D;
    localparam logic [OCTET_W-1:0] FLIP_OCT = 8'h20;

    localparam logic [FCS_LO_W-1:0]  POLY16_REFL = 16'h8408;
    localparam logic [FCS_MAX_W-1:0] POLY32_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_ESC2,
        S_FCS,
        S_ABT_ESC,
        S_ABT_FLAG,
        S_DROP
    } tx_state_t;

    function automatic logic needs_esc(logic [OCTET_W-1:0] b);
        return (b == FLAG_OCT) || (b == ESC_OCT);
    endfunction

    // one octet through the reflected CRC-16, bit 0 first
    function automatic logic [FCS_LO_W-1:0] crc16_step(logic [FCS_LO_W-1:0] c,
                                                       logic [OCTET_W-1:0]  d);
        logic [FCS_LO_W-1:0] r;
        r = c;
        for (int i = 0; i < OCTET_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ POLY16_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // one octet through the reflected CRC-32, bit 0 first
    function automatic logic [FCS_MAX_W-1:0] crc32_step(logic [FCS_MAX_W-1:0] c,
                                                        logic [OCTET_W-1:0]   d);
        logic [FCS_MAX_W-1:0] r;
        r = c;
        for (int i = 0; i < OCTET_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ POLY32_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ppp_fcs_gen.sv
module ppp_fcs_gen
    import ppp_tx_pkg::*;
#(
    parameter int FCS_W = FCS_MAX_W,
    parameter int DW    = OCTET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode32,
    input  logic             init,
    input  logic             upd,
    input  logic [DW-1:0]    din,
    output logic [FCS_W-1:0] fcs_out
);
    localparam int LO_W = FCS_W / 2;

    logic [FCS_W-1:0] crc_q;
    logic [FCS_W-1:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (init) begin
            crc_d = '1;
        end else if (upd) begin
            if (mode32) crc_d = crc32_step(crc_q, din);
            else        crc_d = {crc_q[FCS_W-1:LO_W], crc16_step(crc_q[LO_W-1:0], din)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    // complemented residue, narrow mode zero-extended
    assign fcs_out = mode32 ? ~crc_q : {{(FCS_W-LO_W){1'b0}}, ~crc_q[LO_W-1:0]};

    // R1: the check value only moves on a preset or an accepted octet
    a_r1_fcs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> $stable(fcs_out))
        else $error("a_r1_fcs_hold");
endmodule

// File: rtl/ppp_tx_fsm.sv
module ppp_tx_fsm
    import ppp_tx_pkg::*;
#(
    parameter int DW    = OCTET_W,
    parameter int FCS_W = FCS_MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc32_sel,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             in_err,
    output logic             in_ready,
    input  logic             out_en,
    output logic [DW-1:0]    out_data,
    output logic             ev_good,
    output logic             ev_error,
    output logic             ev_underflow,
    output logic             mode_q,
    output logic             crc_init,
    output logic             crc_upd,
    input  logic [FCS_W-1:0] fcs_in
);
    localparam int FCS_BYTES = FCS_W / DW;
    localparam int IDX_W     = $clog2(FCS_BYTES);
    localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(FCS_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(FCS_BYTES / 2 - 1);

    tx_state_t         state_q, state_d;
    tx_state_t         ret_q, ret_d;
    logic [DW-1:0]     esc_q, esc_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              drop_q, drop_d;
    logic              mode_d;
    logic              good_q, good_d;
    logic              err_q, err_d;
    logic              und_q, und_d;

    logic [FCS_W-1:0]  fcs_shift;
    logic [DW-1:0]     fcs_byte;
    logic              fcs_last;
    tx_state_t         after_data;

    assign fcs_shift = fcs_in >> {idx_q, 3'b000};
    assign fcs_byte  = fcs_shift[DW-1:0];
    assign fcs_last  = (idx_q == (mode_q ? LAST_WIDE : LAST_NARROW));
    assign after_data = !in_eop ? S_DATA : (in_err ? S_ABT_ESC : S_FCS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
            esc_q   <= '0;
            idx_q   <= '0;
            drop_q  <= 1'b0;
            mode_q  <= 1'b0;
            good_q  <= 1'b0;
            err_q   <= 1'b0;
            und_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            esc_q   <= esc_d;
            idx_q   <= idx_d;
            drop_q  <= drop_d;
            mode_q  <= mode_d;
            good_q  <= good_d;
            err_q   <= err_d;
            und_q   <= und_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        esc_d   = esc_q;
        idx_d   = idx_q;
        drop_d  = drop_q;
        mode_d  = mode_q;
        good_d  = 1'b0;
        err_d   = 1'b0;
        und_d   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                mode_d = crc32_sel;
                idx_d  = '0;
                if (out_en && in_valid && in_sop) state_d = S_DATA;
            end
            S_DATA: begin
                if (out_en) begin
                    if (in_valid) begin
                        idx_d  = '0;
                        good_d = in_eop && !in_err;
                        err_d  = in_eop && in_err;
                        if (needs_esc(in_data)) begin
                            esc_d   = in_data ^ FLIP_OCT;
                            ret_d   = after_data;
                            state_d = S_ESC2;
                        end else begin
                            state_d = after_data;
                        end
                    end else begin
                        und_d   = 1'b1;
                        drop_d  = 1'b1;
                        state_d = S_ABT_FLAG;
                    end
                end
            end
            S_ESC2: begin
                if (out_en) state_d = ret_q;
            end
            S_FCS: begin
                if (out_en) begin
                    idx_d = idx_q + 1'b1;
                    if (needs_esc(fcs_byte)) begin
                        esc_d   = fcs_byte ^ FLIP_OCT;
                        ret_d   = fcs_last ? S_IDLE : S_FCS;
                        state_d = S_ESC2;
                    end else begin
                        state_d = fcs_last ? S_IDLE : S_FCS;
                    end
                end
            end
            S_ABT_ESC: begin
                if (out_en) begin
                    drop_d  = 1'b0;
                    state_d = S_ABT_FLAG;
                end
            end
            S_ABT_FLAG: begin
                if (out_en) state_d = drop_q ? S_DROP : S_IDLE;
            end
            S_DROP: begin
                if (in_valid && in_eop) state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        out_data = FLAG_OCT;
        in_ready = 1'b0;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                crc_init = 1'b1;
            end
            S_DATA: begin
                in_ready = out_en;
                crc_upd  = out_en && in_valid;
                if (!in_valid)              out_data = ESC_OCT;
                else if (needs_esc(in_data)) out_data = ESC_OCT;
                else                         out_data = in_data;
            end
            S_ESC2: begin
                out_data = esc_q;
            end
            S_FCS: begin
                out_data = needs_esc(fcs_byte) ? ESC_OCT : fcs_byte;
            end
            S_ABT_ESC: begin
                out_data = ESC_OCT;
            end
            S_ABT_FLAG: begin
                out_data = FLAG_OCT;
            end
            S_DROP: begin
                in_ready = 1'b1;
                crc_init = 1'b1;
            end
        endcase
    end

    assign ev_good      = good_q;
    assign ev_error     = err_q;
    assign ev_underflow = und_q;

    // R6: an escaped payload octet holds the input off for one cycle
    a_r6_escape_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && out_en && in_valid && needs_esc(in_data)) |=> !in_ready)
        else $error("a_r6_escape_backpressure");

    // R2: the second escape byte is never a special octet
    a_r2_second_byte_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ESC2) |-> !needs_esc(out_data))
        else $error("a_r2_second_byte_plain");

    // R7: error strobe follows an accepted end octet carrying the error marker
    a_r7_error_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_error |-> $past(in_valid && in_ready && in_eop && in_err))
        else $error("a_r7_error_event");

    // R10: good strobe follows an accepted clean end octet
    a_r10_good_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_good |-> $past(in_valid && in_ready && in_eop && !in_err))
        else $error("a_r10_good_event");

    // R8: underflow strobe follows an escape octet sent on an empty input
    a_r8_underflow_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_underflow |-> $past(out_en && !in_valid && out_data == ESC_OCT))
        else $error("a_r8_underflow_event");

    // R10: strobes are exclusive
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_good, ev_error, ev_underflow}))
        else $error("a_r10_one_event");

    // R5: without out_en the machine does not advance, except while discarding
    a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && state_q != S_DROP) |=> $stable(state_q))
        else $error("a_r5_hold_when_stalled");
endmodule

// File: rtl/ppp_tx_framer.sv
module ppp_tx_framer
    import ppp_tx_pkg::*;
#(
    parameter int DW    = OCTET_W,
    parameter int FCS_W = FCS_MAX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crc32_sel,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_err,
    output logic          in_ready,
    input  logic          out_en,
    output logic [DW-1:0] out_data,
    output logic          ev_good,
    output logic          ev_error,
    output logic          ev_underflow
);
    logic             mode32;
    logic             crc_init;
    logic             crc_upd;
    logic [FCS_W-1:0] fcs_val;

    ppp_tx_fsm #(.DW(DW), .FCS_W(FCS_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc32_sel    (crc32_sel),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_sop       (in_sop),
        .in_eop       (in_eop),
        .in_err       (in_err),
        .in_ready     (in_ready),
        .out_en       (out_en),
        .out_data     (out_data),
        .ev_good      (ev_good),
        .ev_error     (ev_error),
        .ev_underflow (ev_underflow),
        .mode_q       (mode32),
        .crc_init     (crc_init),
        .crc_upd      (crc_upd),
        .fcs_in       (fcs_val)
    );

    ppp_fcs_gen #(.FCS_W(FCS_W), .DW(DW)) u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode32  (mode32),
        .init    (crc_init),
        .upd     (crc_upd),
        .din     (in_data),
        .fcs_out (fcs_val)
    );
endmodule

// File: tb/test_ppp_tx_framer.sv
module test_ppp_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc32_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       in_err = 1'b0;
    logic       in_ready;
    logic       out_en = 1'b1;
    logic [7:0] out_data;
    logic       ev_good, ev_error, ev_underflow;

    ppp_tx_framer i_ppp_tx_framer (
        .clk(clk), .rst_n(rst_n), .crc32_sel(crc32_sel),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_err(in_err), .in_ready(in_ready),
        .out_en(out_en), .out_data(out_data),
        .ev_good(ev_good), .ev_error(ev_error), .ev_underflow(ev_underflow)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- stimulus data and scoreboard queues
    logic [7:0] pkt[$];
    logic [7:0] fq[$];
    logic [7:0] exp_b[$];
    int         exp_len[$];
    int         exp_gap[$];
    string      exp_tag[$];
    int n_good = 0, n_err = 0, n_und = 0;
    int x_good = 0, x_err = 0, x_und = 0;

    function automatic logic [31:0] model_fcs(input bit m32);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (pkt[k]) begin
            for (int b = 0; b < 8; b++) begin
                if (m32) c = (c[0] ^ pkt[k][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
                else     c[15:0] = (c[0] ^ pkt[k][b]) ? ((c[15:0] >> 1) ^ 16'h8408) : (c[15:0] >> 1);
            end
        end
        return m32 ? ~c : {16'h0, ~c[15:0]};
    endfunction

    task automatic fill_fcs(input bit m32);
        logic [31:0] f = model_fcs(m32);
        fq.delete();
        for (int i = 0; i < (m32 ? 4 : 2); i++) fq.push_back(f[8*i +: 8]);
    endtask

    // kind 0: payload + fq; 1: payload then abort; 2: first cut octets then abort
    task automatic add_exp(input string tag, input int kind, input int cut, input int gap);
        logic [7:0] raw[$];
        int n = 0;
        raw.delete();
        if (kind == 2) begin
            for (int i = 0; i < cut; i++) raw.push_back(pkt[i]);
        end else begin
            foreach (pkt[i]) raw.push_back(pkt[i]);
        end
        if (kind == 0) foreach (fq[i]) raw.push_back(fq[i]);
        foreach (raw[i]) begin
            if (raw[i] == 8'h7E || raw[i] == 8'h7D) begin
                exp_b.push_back(8'h7D); exp_b.push_back(raw[i] ^ 8'h20); n += 2;
            end else begin
                exp_b.push_back(raw[i]); n++;
            end
        end
        if (kind != 0) begin exp_b.push_back(8'h7D); n++; end
        exp_len.push_back(n);
        exp_gap.push_back(gap);
        exp_tag.push_back(tag);
        if (kind == 0) x_good++;
        else if (kind == 1) x_err++;
        else x_und++;
    endtask

    // ---------------- driver
    int first_acc = 0, last_acc = 0;

    task automatic push_byte(input logic [7:0] d, input bit s, input bit e, input bit er);
        bit acc;
        do begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_err = er;
            #1 acc = in_ready;
        end while (!acc);
        last_acc = cyc;
    endtask

    task automatic send_pkt(input bit er, input int cut);
        foreach (pkt[i]) begin
            push_byte(pkt[i], i == 0, i == pkt.size() - 1, er && (i == pkt.size() - 1));
            if (i == 0) first_acc = last_acc;
            if (i + 1 == cut) begin
                @(negedge clk); in_valid = 1'b0;
                repeat (3) @(negedge clk);
            end
        end
    endtask

    task automatic go_idle(input int n);
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // ---------------- downstream enable pattern
    bit         en_rand = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_en = en_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // ---------------- event counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_good) n_good++;
            if (ev_error) n_err++;
            if (ev_underflow) n_und++;
        end
    end

    // ---------------- monitor: cut the line at flags, compare frames
    logic [7:0] cur[$];
    int run = 0, gap_before = 0;

    task automatic finish_frame();
        int len, g, mis;
        string tag;
        logic [7:0] e;
        if (exp_len.size() == 0) begin
            chk(1'b0, "R3", "unexpected frame", cur.size(), 0);
            return;
        end
        len = exp_len.pop_front(); g = exp_gap.pop_front(); tag = exp_tag.pop_front();
        mis = -1;
        for (int i = 0; i < len; i++) begin
            e = exp_b.pop_front();
            if (mis < 0 && (i >= cur.size() || cur[i] != e)) mis = i;
        end
        if (mis < 0 && cur.size() != len) mis = len;
        chk(mis < 0, tag, "frame octets (len / first mismatch index)",
            (mis < 0) ? cur.size() : mis, (mis < 0) ? len : -1);
        if (g >= 0) chk(gap_before == g, "R4", "flags before frame", gap_before, g);
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && out_en) begin
            if (out_data == 8'h7E) begin
                if (cur.size() > 0) begin
                    finish_frame();
                    cur.delete();
                    run = 1;
                end else begin
                    run++;
                end
            end else begin
                if (cur.size() == 0) begin gap_before = run; run = 0; end
                cur.push_back(out_data);
            end
        end
    end

    // ---------------- watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence
    initial begin
        int before_und;
        bit found;
        logic [31:0] f;
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_data == 8'h7E, "R11", "out_data in reset", out_data, 8'h7E);
        chk(in_ready == 1'b0, "R11", "in_ready in reset", in_ready, 0);
        chk({ev_good, ev_error, ev_underflow} == 3'b000, "R11", "events in reset",
            {ev_good, ev_error, ev_underflow}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_data == 8'h7E && !in_ready, "R11", "state after reset", out_data, 8'h7E);

        // R3: idle line carries flags
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            chk(out_data == 8'h7E, "R3", "idle octet", out_data, 8'h7E);
        end

        // R1: CRC-16 check value
        crc32_sel = 1'b0;
        pkt = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        fq = '{8'h6E, 8'h90};
        add_exp("R1 crc16", 0, 0, -1); send_pkt(1'b0, -1); go_idle(12);

        // R1: CRC-32 check value
        crc32_sel = 1'b1;
        fq = '{8'h26, 8'h39, 8'hF4, 8'hCB};
        add_exp("R1 crc32", 0, 0, -1); send_pkt(1'b0, -1); go_idle(12);

        // R2: stuffing in payload, ending on a stuffed octet with the end marker
        crc32_sel = 1'b0;
        pkt = '{8'h7E, 8'h11, 8'h7D, 8'h20, 8'h5E, 8'h00, 8'hFF, 8'h7E};
        fill_fcs(1'b0); add_exp("R2 payload", 0, 0, -1); send_pkt(1'b0, -1); go_idle(8);

        // R6: escaped run accepted at one octet per two cycles
        pkt = '{8'h7E, 8'h7E, 8'h7E, 8'h7E, 8'h7E};
        fill_fcs(1'b0); add_exp("R6 run", 0, 0, -1); send_pkt(1'b0, -1);
        chk(last_acc - first_acc == 8, "R6", "cycles across escaped run", last_acc - first_acc, 8);
        go_idle(8);

        // R2: FCS containing a special octet, then back-to-back sharing (R4)
        found = 1'b0;
        for (int j = 0; j < 65536 && !found; j++) begin
            pkt = '{j[15:8], j[7:0]};
            f = model_fcs(1'b0);
            if (f[7:0] == 8'h7E || f[7:0] == 8'h7D || f[15:8] == 8'h7E || f[15:8] == 8'h7D)
                found = 1'b1;
        end
        chk(found, "R2", "search for stuffed FCS", found, 1);
        fill_fcs(1'b0); add_exp("R2 fcs", 0, 0, -1); send_pkt(1'b0, -1);
        // R4, R12: one-octet packet and a further packet back to back
        pkt = '{8'h42};
        fill_fcs(1'b0); add_exp("R12 single", 0, 0, 1); send_pkt(1'b0, -1);
        pkt = '{8'h7D, 8'h01, 8'h02};
        fill_fcs(1'b0); add_exp("R4 shared", 0, 0, 1); send_pkt(1'b0, -1);
        go_idle(10);

        // R7: error marker ending on a stuffed octet
        pkt = '{8'h10, 8'h20, 8'h7D};
        add_exp("R7 error", 1, 0, -1); send_pkt(1'b1, -1); go_idle(10);

        // R8: underflow after three octets, then a normal packet
        pkt = '{8'hA1, 8'hA2, 8'h7E, 8'hA4, 8'hA5, 8'hA6};
        add_exp("R8 underflow", 2, 3, -1); send_pkt(1'b0, 3);
        pkt = '{8'hB1, 8'hB2};
        fill_fcs(1'b0); add_exp("R8 recovery", 0, 0, -1); send_pkt(1'b0, -1); go_idle(10);

        // R9: gaps between packets are not underflows
        before_und = n_und;
        pkt = '{8'hC1, 8'hC2, 8'hC3};
        fill_fcs(1'b0); add_exp("R9 first", 0, 0, -1); send_pkt(1'b0, -1); go_idle(15);
        pkt = '{8'hD1};
        fill_fcs(1'b0); add_exp("R9 second", 0, 0, -1); send_pkt(1'b0, -1); go_idle(15);
        chk(n_und == before_und, "R9", "underflow count over idle gap", n_und, before_und);

        // R5: random downstream enable, CRC-32 with stuffing
        en_rand = 1'b1;
        crc32_sel = 1'b1;
        pkt.delete();
        for (int i = 0; i < 20; i++) pkt.push_back((i % 5 == 0) ? 8'h7E : 8'(i * 13));
        fill_fcs(1'b1); add_exp("R5 paced", 0, 0, -1); send_pkt(1'b0, -1);
        pkt = '{8'h7D, 8'h55};
        fill_fcs(1'b1); add_exp("R5 paced2", 0, 0, -1); send_pkt(1'b0, -1);
        go_idle(60);
        en_rand = 1'b0;
        go_idle(10);

        chk(exp_len.size() == 0, "R3", "frames still expected", exp_len.size(), 0);
        chk(n_good == x_good, "R10", "good events", n_good, x_good);
        chk(n_err == x_err, "R7", "error events", n_err, x_err);
        chk(n_und == x_und, "R8", "underflow events", n_und, x_und);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule